// File: doc/BRIEF.md
# Four-Channel Left-Aligned PWM Generator with Pair Joining

This block generates four independent left-aligned pulse-width-modulated outputs from a single system clock. Two shared power-of-two dividers derive the channel clocks. The first divider serves channels 0 and 1 and the second serves channels 2 and 3. Each divider also feeds a secondary scaler. Each channel chooses either the plain divided clock of its group or that group's scaled clock. Every channel counts up from zero to its period minus one. Its output sits at one level while the count is below the duty value and at the other level from there to the end of the period.

Channels 0 and 1 can be joined into a single 16-bit generator. Software programs the block through a write port and can inspect it through a combinational read port. Period and duty writes are double-buffered and take effect at a period boundary, so a running waveform never shows a torn cycle.

Top module: `pwmc_top`

## Requirements
- R1: After reset every register reads 0 and, since every polarity bit is 0, all four outputs are 1.
- R2: A 3-bit divider code n gives one channel clock tick every 2^n system cycles. Code A sits at address 1 bits 2:0 and serves channels 0 and 1. Code B sits at address 1 bits 6:4 and serves channels 2 and 3. A channel with duty D and select 0 therefore stays active for D*2^n cycles.
- R3: Clock-select bit i (address 2 bit i) set to 1 switches channel i to its group's scaled clock. That clock ticks once every 2*s divided ticks, where s is the scale register of the group (address 3 for group A, address 4 for group B); s = 0 counts as 256.
- R4: An enabled channel counts 0..P-1 (P = period, addresses 8+i), one step per tick. With polarity bit i (address 2 bit 4+i) at 1, the output is 1 while count < duty (addresses 12+i) and 0 otherwise. Polarity 0 inverts this.
- R5: A channel whose enable bit (address 0 bit i) is 0 holds its count at 0 and drives the inverse of its polarity bit.
- R6: A write to a counter address (16+i) returns that count to 0 on the write edge and loads the pending period and duty. This takes priority over a tick on the same edge.
- R7: Period and duty writes to a running channel take effect only when the count wraps.
- R8: With the join bit (address 0 bit 4) at 1, channels 0 and 1 form one 16-bit generator. Channel 0 supplies the high byte of period, duty and count, and channel 1 the low byte. Its clock is picked by channel 1's select bit, and its enable and polarity come from channel 0. Its waveform appears on output 0, while output 1 stays at channel 1's inactive level.
- R9: A write to address 0 changes the join bit only when enable bits 0 and 1 were both 0 before the write. The enable bits themselves are always written.
- R10: Every register reads back the last value written to it. Counter addresses return the live count, and under joining they return the high and low bytes of the joined count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 5 | Register read address |
| rd_data | output | 8 | Combinational read data |
| pwm_out | output | 4 | Channel outputs |

## Verification
A counter write and a counting tick can land on the same clock edge. With the divider at code 0, every edge is a tick. The bench polls the live count through the read port and asserts a counter write during the cycle in which the count reads 1. It then expects the sampled output stream to restart from count 0 under the new period, rather than continue from 2. A second collision happens when a join-bit change arrives in the same write that enables or disables the pair. The bench judges this through the control readback.

// File: rtl/pwmc_pkg.sv
package pwmc_pkg;
   localparam int AW = 5;
   localparam int NCH = 4;
   localparam logic [AW-1:0] A_CTRL  = 5'd0;
   localparam logic [AW-1:0] A_PRESC = 5'd1;
   localparam logic [AW-1:0] A_CKPOL = 5'd2;
   localparam logic [AW-1:0] A_SCL_A = 5'd3;
   localparam logic [AW-1:0] A_SCL_B = 5'd4;
   localparam logic [AW-1:0] A_PER0  = 5'd8;
   localparam logic [AW-1:0] A_DUT0  = 5'd12;
   localparam logic [AW-1:0] A_CNT0  = 5'd16;
endpackage

// File: rtl/pwmc_clkgen.sv
module pwmc_clkgen #(
   parameter int PSC_W = 3,
   parameter int SCL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [PSC_W-1:0] psc_a,
   input  logic [PSC_W-1:0] psc_b,
   input  logic [SCL_W-1:0] scl_a,
   input  logic [SCL_W-1:0] scl_b,
   output logic [1:0]       tick_base,
   output logic [1:0]       tick_scl
);
   localparam int DIV_W = (1 << PSC_W) - 1;
   localparam int SC_W  = SCL_W + 2;

   generate
      if (PSC_W < 1 || PSC_W > 4) begin : g_bad_psc
         $error("pwmc_clkgen: PSC_W must lie in 1..4");
      end
   endgenerate

   logic [DIV_W-1:0] div_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) div_q <= '0;
      else        div_q <= div_q + DIV_W'(1);
   end

   generate
      for (genvar g = 0; g < 2; g++) begin : g_grp
         logic [PSC_W-1:0] code;
         logic [SCL_W-1:0] scl;
         logic [DIV_W-1:0] mask;
         logic [SC_W-1:0]  lim;
         logic [SC_W-1:0]  sc_q;

         assign code = (g == 0) ? psc_a : psc_b;
         assign scl  = (g == 0) ? scl_a : scl_b;
         assign mask = (DIV_W'(1) << code) - DIV_W'(1);
         assign tick_base[g] = &(div_q | ~mask);
         assign lim  = {(scl == '0), scl, 1'b0} - SC_W'(1);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            sc_q <= '0;
            else if (tick_base[g]) sc_q <= (sc_q >= lim) ? '0 : sc_q + SC_W'(1);
         end

         assign tick_scl[g] = tick_base[g] && (sc_q >= lim);

         // R3: a scaled tick spans at least two divided ticks
         a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
            tick_scl[g] |=> !tick_scl[g]);
      end
   endgenerate
endmodule

// File: rtl/pwmc_chan.sv
module pwmc_chan #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         run,
   input  logic         clr,
   input  logic         pol,
   input  logic [W-1:0] per_in,
   input  logic [W-1:0] dut_in,
   output logic [W-1:0] cnt,
   output logic         pwm
);
   generate
      if (W < 2) begin : g_bad_w
         $error("pwmc_chan: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] per_q, dut_q;
   logic         wrap, below;

   assign wrap  = ({1'b0, cnt} + (W+1)'(1)) >= {1'b0, per_q};
   assign below = cnt < dut_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         per_q <= '0;
         dut_q <= '0;
      end else if (!run || clr) begin
         cnt   <= '0;
         per_q <= per_in;
         dut_q <= dut_in;
      end else if (tick) begin
         if (wrap) begin
            cnt   <= '0;
            per_q <= per_in;
            dut_q <= dut_in;
         end else begin
            cnt <= cnt + W'(1);
         end
      end
   end

   assign pwm = run ? (pol ? below : !below) : !pol;

   // R4: count stays inside the active period
   a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q != '0) |-> (cnt < per_q));
   // R4: a nonzero count came from one step or a hold
   a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
      (run && cnt != '0) |-> ($past(cnt) == cnt - W'(1) || $past(cnt) == cnt));
   // R6: counter write clears on the following cycle
   a_r6_clr_zero: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt == '0));
endmodule

// File: rtl/pwmc_top.sv
module pwmc_top
   import pwmc_pkg::*;
#(
   parameter int DW      = 8,
   parameter int PSC_W   = 3,
   parameter int SCL_W   = 8,
   parameter int JOIN_EN = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [AW-1:0] wr_addr,
   input  logic [DW-1:0] wr_data,
   input  logic [AW-1:0] rd_addr,
   output logic [DW-1:0] rd_data,
   output logic [3:0]    pwm_out
);
   localparam int JW = 2 * DW;

   generate
      if (DW < 8)     begin : g_bad_dw  $error("pwmc_top: DW must be at least 8"); end
      if (SCL_W > DW) begin : g_bad_scl $error("pwmc_top: SCL_W must not exceed DW"); end
   endgenerate

   logic [NCH-1:0]   en_q, sel_q, pol_q;
   logic             cat_q;
   logic [PSC_W-1:0] psa_q, psb_q;
   logic [SCL_W-1:0] scl_a_q, scl_b_q;
   logic [DW-1:0]    per_q [NCH];
   logic [DW-1:0]    dut_q [NCH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0; sel_q <= '0; pol_q <= '0; cat_q <= 1'b0;
         psa_q <= '0; psb_q <= '0; scl_a_q <= '0; scl_b_q <= '0;
         for (int i = 0; i < NCH; i++) begin
            per_q[i] <= '0;
            dut_q[i] <= '0;
         end
      end else if (wr_en) begin
         if (wr_addr == A_CTRL) begin
            en_q <= wr_data[3:0];
            if (JOIN_EN != 0 && en_q[1:0] == 2'b00) cat_q <= wr_data[4];
         end
         if (wr_addr == A_PRESC) begin
            psa_q <= wr_data[PSC_W-1:0];
            psb_q <= wr_data[4 +: PSC_W];
         end
         if (wr_addr == A_CKPOL) begin
            sel_q <= wr_data[3:0];
            pol_q <= wr_data[7:4];
         end
         if (wr_addr == A_SCL_A) scl_a_q <= wr_data[SCL_W-1:0];
         if (wr_addr == A_SCL_B) scl_b_q <= wr_data[SCL_W-1:0];
         for (int i = 0; i < NCH; i++) begin
            if (wr_addr == A_PER0 + AW'(i)) per_q[i] <= wr_data;
            if (wr_addr == A_DUT0 + AW'(i)) dut_q[i] <= wr_data;
         end
      end
   end

   logic [1:0] tick_base, tick_scl;

   pwmc_clkgen #(.PSC_W(PSC_W), .SCL_W(SCL_W)) u_clkgen (
      .clk(clk), .rst_n(rst_n),
      .psc_a(psa_q), .psc_b(psb_q),
      .scl_a(scl_a_q), .scl_b(scl_b_q),
      .tick_base(tick_base), .tick_scl(tick_scl)
   );

   logic           join_on;
   logic [NCH-1:0] ch_tick, ch_run, ch_clr, ch_pwm;
   logic [DW-1:0]  ch_cnt [NCH];
   logic [JW-1:0]  j_cnt;
   logic           j_pwm;

   generate
      for (genvar i = 0; i < NCH; i++) begin : g_ch
         assign ch_tick[i] = sel_q[i] ? tick_scl[i/2] : tick_base[i/2];
         assign ch_run[i]  = en_q[i] & ~(join_on & (i < 2));
         assign ch_clr[i]  = wr_en && (wr_addr == A_CNT0 + AW'(i));
         pwmc_chan #(.W(DW)) u_chan (
            .clk(clk), .rst_n(rst_n), .tick(ch_tick[i]), .run(ch_run[i]),
            .clr(ch_clr[i]), .pol(pol_q[i]), .per_in(per_q[i]), .dut_in(dut_q[i]),
            .cnt(ch_cnt[i]), .pwm(ch_pwm[i])
         );
      end

      if (JOIN_EN != 0) begin : g_join
         assign join_on = cat_q;
         pwmc_chan #(.W(JW)) u_join (
            .clk(clk), .rst_n(rst_n), .tick(ch_tick[1]), .run(cat_q & en_q[0]),
            .clr(ch_clr[0] | ch_clr[1]), .pol(pol_q[0]),
            .per_in({per_q[0], per_q[1]}), .dut_in({dut_q[0], dut_q[1]}),
            .cnt(j_cnt), .pwm(j_pwm)
         );
      end else begin : g_nojoin
         assign join_on = 1'b0;
         assign j_cnt   = '0;
         assign j_pwm   = 1'b0;
      end
   endgenerate

   assign pwm_out = {ch_pwm[3:1], join_on ? j_pwm : ch_pwm[0]};

   always_comb begin
      rd_data = '0;
      if (rd_addr == A_CTRL)  rd_data = DW'({cat_q, en_q});
      if (rd_addr == A_PRESC) begin
         rd_data[PSC_W-1:0]  = psa_q;
         rd_data[4 +: PSC_W] = psb_q;
      end
      if (rd_addr == A_CKPOL) rd_data = DW'({pol_q, sel_q});
      if (rd_addr == A_SCL_A) rd_data = DW'(scl_a_q);
      if (rd_addr == A_SCL_B) rd_data = DW'(scl_b_q);
      for (int i = 0; i < NCH; i++) begin
         if (rd_addr == A_PER0 + AW'(i)) rd_data = per_q[i];
         if (rd_addr == A_DUT0 + AW'(i)) rd_data = dut_q[i];
         if (rd_addr == A_CNT0 + AW'(i)) begin
            if (join_on && i == 0)      rd_data = j_cnt[JW-1:DW];
            else if (join_on && i == 1) rd_data = j_cnt[DW-1:0];
            else                        rd_data = ch_cnt[i];
         end
      end
   end

   // R9: join bit moves only when the pair was idle before the write
   a_r9_join_lock: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cat_q) |-> ($past(en_q[1:0]) == 2'b00));
   // R8: while joined, output 1 rests at its inactive level
   a_r8_pin1_idle: assert property (@(posedge clk) disable iff (!rst_n)
      cat_q |-> (pwm_out[1] == !pol_q[1]));
endmodule

// File: tb/pwmc_top_bench.sv
module pwmc_top_bench;
   import pwmc_pkg::*;
   localparam int CLK_P = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_en = 1'b0;
   logic [AW-1:0] wr_addr = '0;
   logic [7:0]    wr_data = '0;
   logic [AW-1:0] rd_addr = '0;
   logic [7:0]    rd_data;
   logic [3:0]    pwm_out;

   pwmc_top u_pwmc_top (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
   );

   always #(CLK_P/2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct {
      logic [3:0] mask;
      logic [3:0] val;
      string      tag;
   } sb_item_t;
   sb_item_t sb[$];

   int m_per[4], m_dut[4];
   bit m_pol[4], m_en[4];
   bit m_join = 1'b0;
   int j_per = 1, j_dut = 0;

   task automatic chk(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic bit exp_bit(int ch, int k);
      bit hi;
      if (m_join && ch == 1) return !m_pol[1];
      if (!m_en[ch]) return !m_pol[ch];
      if (m_join && ch == 0) hi = (k % j_per) < j_dut;
      else                   hi = (k % m_per[ch]) < m_dut[ch];
      return m_pol[ch] ? hi : !hi;
   endfunction

   task automatic push(int k0, int n, logic [3:0] mask, string tag);
      for (int k = k0; k < k0 + n; k++) begin
         sb_item_t it;
         it.mask = mask;
         it.tag  = tag;
         for (int ch = 0; ch < 4; ch++) it.val[ch] = exp_bit(ch, k);
         sb.push_back(it);
      end
   endtask

   always @(negedge clk) begin
      if (sb.size() != 0) begin
         sb_item_t it;
         it = sb.pop_front();
         chk((pwm_out & it.mask) == (it.val & it.mask), it.tag,
             int'(pwm_out & it.mask), int'(it.val & it.mask));
      end
   end

   task automatic drain();
      while (sb.size() != 0) @(negedge clk);
   endtask

   task automatic wr(logic [AW-1:0] a, logic [7:0] d);
      @(posedge clk); #1;
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(logic [AW-1:0] a, int exp, string tag);
      @(negedge clk);
      rd_addr = a; #1;
      chk(int'(rd_data) == exp, tag, int'(rd_data), exp);
   endtask

   task automatic measure_high(int ch, int exp, string tag);
      int len = 0;
      int guard = 0;
      while (pwm_out[ch] != 1'b0 && guard < 2000) begin @(negedge clk); guard++; end
      while (pwm_out[ch] != 1'b1 && guard < 2000) begin @(negedge clk); guard++; end
      while (pwm_out[ch] == 1'b1 && guard < 2000) begin @(negedge clk); len++; guard++; end
      chk(len == exp, tag, len, exp);
   endtask

   task automatic clr_when(int ch, int val);
      for (int g = 0; g < 50; g++) begin
         @(negedge clk);
         rd_addr = A_CNT0 + AW'(ch); #1;
         if (int'(rd_data) == val) begin
            wr_en = 1'b1; wr_addr = A_CNT0 + AW'(ch); wr_data = 8'h00;
            @(posedge clk); #1;
            wr_en = 1'b0;
            return;
         end
      end
      chk(1'b0, "R6 poll", 0, val);
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
   endtask

   initial begin
      #(CLK_P * 200000);
      chk(1'b0, "watchdog", 0, 1);
      summary();
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin m_per[i] = 1; m_dut[i] = 0; m_pol[i] = 0; m_en[i] = 0; end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      for (int a = 0; a < 5; a++) rd_chk(AW'(a), 0, "R1 reg");
      for (int a = 8; a < 20; a++) rd_chk(AW'(a), 0, "R1 chan reg");
      chk(pwm_out == 4'hF, "R1 outputs", int'(pwm_out), 15);

      // R4: basic waveforms, undivided clock
      wr(A_CKPOL, 8'hF0);
      wr(A_PER0 + 0, 8'd5); wr(A_DUT0 + 0, 8'd2);
      wr(A_PER0 + 1, 8'd4); wr(A_DUT0 + 1, 8'd3);
      wr(A_PER0 + 2, 8'd6); wr(A_DUT0 + 2, 8'd0);
      wr(A_PER0 + 3, 8'd3); wr(A_DUT0 + 3, 8'd3);
      for (int i = 0; i < 4; i++) m_pol[i] = 1;
      m_per = '{5, 4, 6, 3}; m_dut = '{2, 3, 0, 3};
      rd_chk(A_PER0 + 1, 4, "R10 period readback");
      rd_chk(A_CKPOL, 8'hF0, "R10 ckpol readback");
      wr(A_CTRL, 8'h0F);
      for (int i = 0; i < 4; i++) m_en[i] = 1;
      push(0, 20, 4'hF, "R4 left aligned");
      drain();

      // R5: disabled channels
      wr(A_CTRL, 8'h00);
      for (int i = 0; i < 4; i++) m_en[i] = 0;
      push(0, 1, 4'hF, "R5 idle level");
      drain();
      rd_chk(A_CNT0, 0, "R5 idle count");

      // R4: inverted polarity on channel 2
      wr(A_CKPOL, 8'hB0);
      m_pol[2] = 0;
      wr(A_CTRL, 8'h0F);
      for (int i = 0; i < 4; i++) m_en[i] = 1;
      push(0, 12, 4'hF, "R4 polarity");
      drain();

      // R7: duty change waits for wrap
      wr(A_CTRL, 8'h00);
      for (int i = 0; i < 4; i++) m_en[i] = 0;
      wr(A_CTRL, 8'h08);
      m_en[3] = 1;
      wr(A_DUT0 + 3, 8'd1);
      push(2, 1, 4'h8, "R7 old duty");
      m_dut[3] = 1;
      push(3, 9, 4'h8, "R7 new duty");
      drain();

      // R6: counter write on a counting edge
      wr(A_PER0 + 3, 8'd5);
      m_per[3] = 5;
      clr_when(3, 1);
      push(0, 10, 4'h8, "R6 counter write");
      drain();

      // R2 / R3: divided and scaled clocks
      wr(A_CTRL, 8'h00);
      for (int i = 0; i < 4; i++) m_en[i] = 0;
      wr(A_PRESC, 8'h32);
      wr(A_SCL_A, 8'd3);
      wr(A_SCL_B, 8'd1);
      wr(A_CKPOL, 8'hFA);
      for (int i = 0; i < 4; i++) wr(A_PER0 + AW'(i), 8'd4);
      wr(A_DUT0 + 0, 8'd2); wr(A_DUT0 + 1, 8'd1);
      wr(A_DUT0 + 2, 8'd3); wr(A_DUT0 + 3, 8'd2);
      rd_chk(A_PRESC, 8'h32, "R10 presc readback");
      rd_chk(A_SCL_A, 3, "R10 scale readback");
      wr(A_CTRL, 8'h0F);
      measure_high(0, 8, "R2 group A divide");
      measure_high(2, 24, "R2 group B divide");
      measure_high(1, 24, "R3 scaled A");
      measure_high(3, 32, "R3 scaled B");

      // R8: joined 16-bit channel
      wr(A_CTRL, 8'h00);
      wr(A_CTRL, 8'h10);
      rd_chk(A_CTRL, 8'h10, "R8 join set while idle");
      wr(A_PRESC, 8'h00);
      wr(A_CKPOL, 8'hF1);
      wr(A_PER0 + 0, 8'h01); wr(A_PER0 + 1, 8'h04);
      wr(A_DUT0 + 0, 8'h00); wr(A_DUT0 + 1, 8'h82);
      for (int i = 0; i < 4; i++) begin m_pol[i] = 1; m_en[i] = 0; end
      wr(A_CTRL, 8'h13);
      m_join = 1; m_en[0] = 1; m_en[1] = 1;
      j_per = 260; j_dut = 130;
      push(0, 300, 4'hF, "R8 joined waveform");
      drain();

      // R9: join bit locked while the pair runs
      wr(A_CTRL, 8'h03);
      rd_chk(A_CTRL, 8'h13, "R9 ignored while running");
      wr(A_CTRL, 8'h00);
      rd_chk(A_CTRL, 8'h10, "R9 ignored on disabling write");
      wr(A_CTRL, 8'h00);
      rd_chk(A_CTRL, 8'h00, "R9 cleared while idle");
      m_join = 0;
      for (int i = 0; i < 4; i++) m_en[i] = 0;
      push(0, 1, 4'hF, "R5 idle after join");
      drain();

      summary();
      $finish;
   end
endmodule